// File: doc/BRIEF.md
# Selective-Wake Status Flag Controller

This block keeps the status and error flags of a CAN selective-wake front end that sits inside a system power-mode controller. It watches the current power mode, the state of the wake detector, pulses from a bus-silence timer, results from a frame checker, wake-pattern and wake-frame events, and host register writes. From these it maintains six flags: a configuration-valid bit, a system-error flag, a bus-timeout flag, a bus-silence flag, a sync flag and a selective-wake-set flag. It also produces a maskable, single-cycle bus-timeout interrupt.

The flags are not plain write-one-to-clear bits. Each one has its own rules for setting and clearing. Those rules depend on the power mode, the wake-detector state, the CAN channel mode and the register address the host writes. The protocol decoder, the silence timer and the transceiver are outside this block and appear only as one-cycle event pulses. All flags are registered, so each one changes on the clock edge that samples its cause.

Top module: `swk_flag_ctrl`

## Requirements
- R1: After the active-low reset, every flag output and `toIrq` are 0.
- R2: In Normal mode (`pwrMode`=0), a write to any address from 0x22 to 0x33 clears `cfgValid`. A write to the control address 0x21 with data bit 7 at 1 sets `cfgValid`. A write to 0x21 with bit 7 at 0 leaves it unchanged, and so does a write to any other address.
- R3: In Stop (1) and Sleep (2) modes, writes to 0x21 through 0x33 leave `cfgValid` unchanged.
- R4: On entry to Restart mode (3), `cfgValid` is cleared. `sysErr` is set on entry if `canModeSel[2]` (selective wake enabled) is 1, unless the most recent wake before the restart was a wake frame (`wufDet`) seen in Sleep mode.
- R5: A write to the status address 0x40 with data bit 0 at 1 clears `sysErr`. The clear is refused while `canModeSel[2]` is 1 and `cfgValid` is 0.
- R6: A wake-frame pulse `wufDet` clears `cfgValid` in any mode.
- R7: A `silenceExp` pulse sets both `busTimeout` and `busSilent` when `wakeState` is 1 (wake-frame detection) or 3 (wake-pattern detection 2). In any other wake state the pulse has no effect.
- R8: A write to 0x40 with data bit 1 at 1 clears `busTimeout`. If a qualifying `silenceExp` arrives in the same cycle, the flag ends up at 1.
- R9: `toIrq` is high for exactly one cycle, on the same edge that records a qualifying timeout, when `toMask` is 1 and the mode is Normal or Stop. This happens on every such event, even if `busTimeout` was never cleared. In Sleep mode, or with the mask at 0, no pulse is produced.
- R10: `busSilent` is cleared by a wake-pattern pulse `wupDet`. Host writes to 0x40 leave it unchanged.
- R11: `syncOk` is updated only while `canModeSel[1]` is 1 (receive-only 2'b10 or normal 2'b11 in bits 1:0) or `wakeState` is 1. Within that window, `frameOk` sets it, `frameErr` clears it, and an error wins when both arrive. Outside the window, both pulses are ignored.
- R12: `swkSet` is set while `canModeSel[2]` is 1 and either of two conditions holds. The first is `cfgValid` at 1 with `wakeState` at 1 or 2. The second is `sysErr` at 1 with `wakeState` at 3. `swkSet` is cleared by `wupDet`, by `wufDet`, or by `canModeSel[2]` at 0, and a clear wins over a set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low power-on reset, synchronous |
| pwrMode | input | 2 | Power mode: 0 Normal, 1 Stop, 2 Sleep, 3 Restart |
| wakeState | input | 2 | Wake detector: 0 idle, 1 wake-frame detect, 2 pattern detect 1, 3 pattern detect 2 |
| canModeSel | input | 3 | CAN mode; bit 2 enables selective wake, bits 1:0 channel mode |
| toMask | input | 1 | Enable for the bus-timeout interrupt |
| silenceExp | input | 1 | Silence-time expiry pulse |
| frameOk | input | 1 | Frame received without CRC or stuffing error |
| frameErr | input | 1 | Protocol error detected |
| wupDet | input | 1 | Wake pattern detected |
| wufDet | input | 1 | Wake frame detected |
| wrEn | input | 1 | Host register write strobe |
| wrAddr | input | 7 | Host write address |
| wrData | input | 8 | Host write data |
| cfgValid | output | 1 | Selective-wake configuration valid |
| sysErr | output | 1 | System error flag |
| busTimeout | output | 1 | Bus timeout flag |
| busSilent | output | 1 | Bus silence flag |
| syncOk | output | 1 | Frame detection synchronised to the bus |
| swkSet | output | 1 | Selective wake armed |
| toIrq | output | 1 | Bus-timeout interrupt pulse |

## Verification
Two functions can land on the same edge: the host's clear of `busTimeout` and a silence-time expiry that sets it. The bench provokes this by holding a status write with bit 1 and a `silenceExp` pulse in one cycle while in pattern-detect state 2, and it expects the flag to read 1 afterwards. A second clash involves the host's `sysErr` clear and the refusal rule. The bench issues the clear with selective wake enabled and the configuration invalid, expects the flag to stay set, then revalidates and expects the same write to succeed.

// File: rtl/swk_flag_pkg.sv
package swk_flag_pkg;

  typedef enum logic [1:0] {
    PM_NORMAL  = 2'd0,
    PM_STOP    = 2'd1,
    PM_SLEEP   = 2'd2,
    PM_RESTART = 2'd3
  } pwrMode_e;

  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_FRAME = 2'd1,
    WS_PAT1  = 2'd2,
    WS_PAT2  = 2'd3
  } wakeState_e;

  // Set/clear strobes from control to the flag datapath
  typedef struct packed {
    logic cfgSet;
    logic cfgClr;
    logic errSet;
    logic errClr;
    logic toSet;
    logic toClr;
    logic silSet;
    logic silClr;
    logic syncSet;
    logic syncClr;
    logic armSet;
    logic armClr;
    logic irq;
  } flagStb_t;

endpackage

// File: rtl/swk_flag_ctl.sv
module swk_flag_ctl
  import swk_flag_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 7'h21,
  parameter logic [ADDR_W-1:0] CFG_LO    = 7'h22,
  parameter logic [ADDR_W-1:0] CFG_HI    = 7'h33,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 7'h40,
  parameter int CFG_SET_BIT = 7,
  parameter int ERR_CLR_BIT = 0,
  parameter int TO_CLR_BIT  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        pwrMode,
  input  logic [1:0]        wakeState,
  input  logic [2:0]        canModeSel,
  input  logic              toMask,
  input  logic              silenceExp,
  input  logic              frameOk,
  input  logic              frameErr,
  input  logic              wupDet,
  input  logic              wufDet,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              cfgValid,
  input  logic              sysErr,
  output flagStb_t          stb
);

  pwrMode_e   mode;
  wakeState_e ws;
  logic prevRestart;
  logic wufSleep;
  logic restartEntry, isNormal, swkOn;
  logic cfgWr, ctrlWr, statWr, timeoutEv, syncWin;

  assign mode = pwrMode_e'(pwrMode);
  assign ws   = wakeState_e'(wakeState);

  assign isNormal     = (mode == PM_NORMAL);
  assign swkOn        = canModeSel[2];
  assign restartEntry = (mode == PM_RESTART) && !prevRestart;

  assign cfgWr  = wrEn && isNormal && (wrAddr >= CFG_LO) && (wrAddr <= CFG_HI);
  assign ctrlWr = wrEn && isNormal && (wrAddr == CTRL_ADDR);
  assign statWr = wrEn && (wrAddr == STAT_ADDR);

  assign timeoutEv = silenceExp && (ws == WS_FRAME || ws == WS_PAT2);
  assign syncWin   = canModeSel[1] || (ws == WS_FRAME);

  // Restart detection and wake-frame-from-sleep memory
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevRestart <= 1'b0;
      wufSleep    <= 1'b0;
    end else begin
      prevRestart <= (mode == PM_RESTART);
      if (restartEntry)
        wufSleep <= 1'b0;
      else if (wufDet && mode == PM_SLEEP)
        wufSleep <= 1'b1;
    end
  end

  always_comb begin
    stb         = '0;
    stb.cfgSet  = ctrlWr && wrData[CFG_SET_BIT];
    stb.cfgClr  = cfgWr || restartEntry || wufDet;
    stb.errSet  = restartEntry && swkOn && !wufSleep;
    stb.errClr  = statWr && wrData[ERR_CLR_BIT] && !(swkOn && !cfgValid);
    stb.toSet   = timeoutEv;
    stb.toClr   = statWr && wrData[TO_CLR_BIT];
    stb.silSet  = timeoutEv;
    stb.silClr  = wupDet;
    stb.syncSet = syncWin && frameOk;
    stb.syncClr = syncWin && frameErr;
    stb.armSet  = swkOn && ((cfgValid && (ws == WS_FRAME || ws == WS_PAT1)) ||
                            (sysErr && ws == WS_PAT2));
    stb.armClr  = !swkOn || wupDet || wufDet;
    stb.irq     = timeoutEv && toMask && (mode == PM_NORMAL || mode == PM_STOP);
  end

  // R5: refused clear keeps the error flag
  a_r5_clear_refused: assert property (@(posedge clk) disable iff (!rstN)
    (sysErr && canModeSel[2] && !cfgValid) |=> sysErr);

  // R6: wake frame invalidates configuration
  a_r6_wuf_drops_cfg: assert property (@(posedge clk) disable iff (!rstN)
    wufDet |=> !cfgValid);

endmodule

// File: rtl/swk_flag_dp.sv
module swk_flag_dp
  import swk_flag_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  flagStb_t stb,
  output logic     cfgValid,
  output logic     sysErr,
  output logic     busTimeout,
  output logic     busSilent,
  output logic     syncOk,
  output logic     swkSet,
  output logic     toIrq
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgValid   <= 1'b0;
      sysErr     <= 1'b0;
      busTimeout <= 1'b0;
      busSilent  <= 1'b0;
      syncOk     <= 1'b0;
      swkSet     <= 1'b0;
      toIrq      <= 1'b0;
    end else begin
      // invalidation wins over host validation
      if (stb.cfgClr)      cfgValid <= 1'b0;
      else if (stb.cfgSet) cfgValid <= 1'b1;
      // error events win over host clears
      if (stb.errSet)      sysErr <= 1'b1;
      else if (stb.errClr) sysErr <= 1'b0;
      if (stb.toSet)       busTimeout <= 1'b1;
      else if (stb.toClr)  busTimeout <= 1'b0;
      if (stb.silSet)      busSilent <= 1'b1;
      else if (stb.silClr) busSilent <= 1'b0;
      // protocol error wins over a good frame
      if (stb.syncClr)      syncOk <= 1'b0;
      else if (stb.syncSet) syncOk <= 1'b1;
      if (stb.armClr)      swkSet <= 1'b0;
      else if (stb.armSet) swkSet <= 1'b1;
      toIrq <= stb.irq;
    end
  end

  // R8: timeout set beats a simultaneous host clear
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (stb.toSet && stb.toClr) |=> busTimeout);

  // R9: an interrupt always comes with the recorded flag
  a_r9_irq_with_flag: assert property (@(posedge clk) disable iff (!rstN)
    toIrq |-> busTimeout);

  // R11: a protocol error always drops sync
  a_r11_error_drops_sync: assert property (@(posedge clk) disable iff (!rstN)
    stb.syncClr |=> !syncOk);

  // R10: silence flag only rises through a timeout event
  a_r10_sil_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busSilent) |-> $past(stb.silSet));

endmodule

// File: rtl/swk_flag_ctrl.sv
module swk_flag_ctrl
  import swk_flag_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        pwrMode,
  input  logic [1:0]        wakeState,
  input  logic [2:0]        canModeSel,
  input  logic              toMask,
  input  logic              silenceExp,
  input  logic              frameOk,
  input  logic              frameErr,
  input  logic              wupDet,
  input  logic              wufDet,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              cfgValid,
  output logic              sysErr,
  output logic              busTimeout,
  output logic              busSilent,
  output logic              syncOk,
  output logic              swkSet,
  output logic              toIrq
);

  flagStb_t stb;

  swk_flag_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rstN(rstN), .pwrMode(pwrMode), .wakeState(wakeState),
    .canModeSel(canModeSel), .toMask(toMask), .silenceExp(silenceExp),
    .frameOk(frameOk), .frameErr(frameErr), .wupDet(wupDet), .wufDet(wufDet),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cfgValid(cfgValid), .sysErr(sysErr), .stb(stb)
  );

  swk_flag_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .cfgValid(cfgValid), .sysErr(sysErr), .busTimeout(busTimeout),
    .busSilent(busSilent), .syncOk(syncOk), .swkSet(swkSet), .toIrq(toIrq)
  );

endmodule

// File: tb/swk_flag_ctrl_tb.sv
module swk_flag_ctrl_tb;

  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] pwrMode = 2'd0;
  logic [1:0] wakeState = 2'd0;
  logic [2:0] canModeSel = 3'd0;
  logic toMask = 1'b0;
  logic silenceExp = 1'b0, frameOk = 1'b0, frameErr = 1'b0;
  logic wupDet = 1'b0, wufDet = 1'b0, wrEn = 1'b0;
  logic [6:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic cfgValid, sysErr, busTimeout, busSilent, syncOk, swkSet, toIrq;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  swk_flag_ctrl u_dut (
    .clk(clk), .rstN(rstN), .pwrMode(pwrMode), .wakeState(wakeState),
    .canModeSel(canModeSel), .toMask(toMask), .silenceExp(silenceExp),
    .frameOk(frameOk), .frameErr(frameErr), .wupDet(wupDet), .wufDet(wufDet),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cfgValid(cfgValid), .sysErr(sysErr), .busTimeout(busTimeout),
    .busSilent(busSilent), .syncOk(syncOk), .swkSet(swkSet), .toIrq(toIrq)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // one edge, then drop all pulses
  task automatic tick();
    @(posedge clk); #1;
    silenceExp = 0; frameOk = 0; frameErr = 0;
    wupDet = 0; wufDet = 0; wrEn = 0;
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    wrEn = 1; wrAddr = a; wrData = d;
    tick();
  endtask

  task automatic t_reset();
    chk("R1 cfgValid", cfgValid, 0); chk("R1 sysErr", sysErr, 0);
    chk("R1 busTimeout", busTimeout, 0); chk("R1 busSilent", busSilent, 0);
    chk("R1 syncOk", syncOk, 0); chk("R1 swkSet", swkSet, 0);
    chk("R1 toIrq", toIrq, 0);
  endtask

  task automatic t_cfg();
    pwrMode = 0;
    wr(7'h21, 8'h80); chk("R2 ctrl sets", cfgValid, 1);
    wr(7'h21, 8'h00); chk("R2 ctrl keeps", cfgValid, 1);
    wr(7'h25, 8'h00); chk("R2 cfg clears", cfgValid, 0);
    wr(7'h21, 8'h80);
    wr(7'h33, 8'h00); chk("R2 top of range", cfgValid, 0);
    wr(7'h21, 8'h80);
    wr(7'h34, 8'h00); chk("R2 above range", cfgValid, 1);
    wr(7'h20, 8'h00); chk("R2 below range", cfgValid, 1);
  endtask

  task automatic t_lock();
    pwrMode = 1; wr(7'h25, 8'h00); chk("R3 stop locked", cfgValid, 1);
    pwrMode = 2; wr(7'h22, 8'h00); chk("R3 sleep locked", cfgValid, 1);
    pwrMode = 0;
  endtask

  task automatic t_restart_err();
    canModeSel = 3'b100;
    pwrMode = 3; tick(); tick();
    chk("R4 restart clears cfg", cfgValid, 0);
    chk("R4 restart sets err", sysErr, 1);
    pwrMode = 0; tick();
    wr(7'h40, 8'h01); chk("R5 clear refused", sysErr, 1);
    wr(7'h21, 8'h80);
    wr(7'h40, 8'h01); chk("R5 clear accepted", sysErr, 0);
    pwrMode = 2; wufDet = 1; tick();
    chk("R6 wuf clears cfg", cfgValid, 0);
    pwrMode = 3; tick();
    chk("R4 wuf wake no err", sysErr, 0);
    pwrMode = 0; tick();
    canModeSel = 3'b000;
    wr(7'h21, 8'h80);
    pwrMode = 3; tick();
    chk("R4 swk off no err", sysErr, 0);
    chk("R4 swk off cfg cleared", cfgValid, 0);
    pwrMode = 0; tick();
    wr(7'h21, 8'h80);
    wufDet = 1; tick(); chk("R6 wuf in normal", cfgValid, 0);
  endtask

  task automatic t_timeout();
    pwrMode = 0; toMask = 1; wakeState = 0;
    silenceExp = 1; tick();
    chk("R7 idle ignored to", busTimeout, 0);
    chk("R7 idle ignored sil", busSilent, 0);
    chk("R9 idle no irq", toIrq, 0);
    wakeState = 1; silenceExp = 1; tick();
    chk("R7 frame sets to", busTimeout, 1);
    chk("R7 frame sets sil", busSilent, 1);
    chk("R9 irq pulse", toIrq, 1);
    tick(); chk("R9 irq one cycle", toIrq, 0);
    silenceExp = 1; tick(); chk("R9 irq again uncleared", toIrq, 1);
    pwrMode = 2; silenceExp = 1; tick(); chk("R9 no irq in sleep", toIrq, 0);
    pwrMode = 1; toMask = 0; silenceExp = 1; tick(); chk("R9 masked", toIrq, 0);
    pwrMode = 1; toMask = 1; silenceExp = 1; tick(); chk("R9 irq in stop", toIrq, 1);
    pwrMode = 0; wakeState = 0; tick();
    wr(7'h40, 8'h02);
    chk("R8 host clear", busTimeout, 0);
    chk("R10 host no sil clear", busSilent, 1);
    wakeState = 3; wrEn = 1; wrAddr = 7'h40; wrData = 8'h02; silenceExp = 1; tick();
    chk("R8 set wins", busTimeout, 1);
    wakeState = 0;
    wr(7'h40, 8'hFF); chk("R10 all-ones write", busSilent, 1);
    wupDet = 1; tick(); chk("R10 pattern clears", busSilent, 0);
  endtask

  task automatic t_sync();
    canModeSel = 3'b000; wakeState = 0;
    frameOk = 1; tick(); chk("R11 outside window", syncOk, 0);
    canModeSel = 3'b011;
    frameOk = 1; tick(); chk("R11 good frame", syncOk, 1);
    frameErr = 1; tick(); chk("R11 error clears", syncOk, 0);
    frameOk = 1; tick();
    frameOk = 1; frameErr = 1; tick(); chk("R11 error wins", syncOk, 0);
    canModeSel = 3'b010; frameOk = 1; tick(); chk("R11 receive-only", syncOk, 1);
    canModeSel = 3'b000; frameErr = 1; tick(); chk("R11 error ignored", syncOk, 1);
    frameErr = 1; wakeState = 1; tick(); chk("R11 frame-detect window", syncOk, 0);
    wakeState = 0;
  endtask

  task automatic t_arm();
    pwrMode = 0; canModeSel = 3'b100; wakeState = 0;
    wr(7'h21, 8'h80);
    chk("R12 idle not armed", swkSet, 0);
    wakeState = 2; tick(); chk("R12 pattern1 arms", swkSet, 1);
    wakeState = 0; tick(); chk("R12 holds", swkSet, 1);
    wupDet = 1; tick(); chk("R12 pattern clears", swkSet, 0);
    wakeState = 1; tick(); chk("R12 frame arms", swkSet, 1);
    canModeSel = 3'b000; tick(); chk("R12 disable clears", swkSet, 0);
    canModeSel = 3'b100; wakeState = 0;
    pwrMode = 3; tick(); pwrMode = 0; tick();
    chk("R4 err for arm test", sysErr, 1);
    wakeState = 3; tick(); chk("R12 error arms", swkSet, 1);
    wufDet = 1; tick(); chk("R12 wake clear wins", swkSet, 0);
    wakeState = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    t_reset();
    t_cfg();
    t_lock();
    t_restart_err();
    t_timeout();
    t_sync();
    t_arm();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!finished) begin
      finished = 1'b1;
      nChecks++; nErrors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

endmodule